// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two signed two's-complement operands of `WIDTH` bits over several clock cycles. It uses Booth recoding: in every step it inspects the lowest multiplier bit together with a saved copy of the bit shifted out before it. Depending on that pair, it subtracts the multiplicand from a partial-sum register, adds it, or leaves the register alone. It then shifts the partial sum and the multiplier one place to the right as a single arithmetic shift. A run of ones in the multiplier therefore costs one subtraction where the run starts and one addition where it ends. Negative multipliers and negative multiplicands need no separate sign-correction pass.

A caller raises `start` for one cycle while the block is not running, with both operands on the inputs. The block is then `busy` for exactly `WIDTH` cycles. It then raises `done` for one cycle, with the full `2*WIDTH`-bit product on `product`. The product stays there until the next accepted start. Control is a three-state machine:

- **IDLE**: waits for a start. On start it goes to **RUN**.
- **RUN**: performs one recode/add/shift step per cycle. It stays in RUN until the step counter reaches its last step, then goes to **FINISH**.
- **FINISH**: holds `done` for one cycle. On start it goes straight back to **RUN**. Otherwise it goes to **IDLE**.

Top module: `booth_mult`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `product` is 0.
- R2: A `start` seen at a clock edge in IDLE or FINISH captures both operands, and `busy` is 1 from the next cycle on.
- R3: `busy` stays 1 for exactly `WIDTH` cycles. It is followed by exactly one cycle with `done` = 1 and `busy` = 0. `busy` and `done` are never 1 together.
- R4: When `done` is 1, `product` equals the signed product of the captured operands, with bit `2*WIDTH-1` as the sign. This holds for every operand pair, including the most negative value on either input or on both.
- R5: A negative multiplier (most significant bit 1), including all ones and the most negative value, gives the correct signed product without either operand being made positive first.
- R6: A `start` raised while `busy` is 1 is ignored. The running result, and the cycle on which `done` appears, are unchanged.
- R7: While the block is not busy and no start is accepted, `product` holds its value, whatever the operand inputs do.
- R8: A `start` in the cycle `done` is 1 is accepted, and a new multiplication begins without passing through IDLE.
- R9: Changing the operand inputs while `busy` is 1, with no start, has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a multiplication |
| multiplicand | input | WIDTH | Signed multiplicand, captured on an accepted start |
| multiplier | input | WIDTH | Signed multiplier, captured on an accepted start |
| busy | output | 1 | High while the steps run |
| done | output | 1 | One-cycle pulse when the product is ready |
| product | output | 2*WIDTH | Signed double-width product |

## Verification
The bench builds the block twice: once with `WIDTH` = 8 and once with `WIDTH` = 4. The 8-bit instance runs a table of hand-picked pairs and a strided sweep over the signed range. It also runs the directed tests for start-while-busy, operand changes mid-run, back-to-back starts and product hold. The 4-bit instance is small enough for every one of its 256 operand pairs to be multiplied. That sweep reaches the most-negative-times-most-negative and most-negative-times-one corners exhaustively.

// File: rtl/booth_pkg.sv
package booth_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FINISH
    } booth_state_e;

    typedef enum logic [1:0] {
        OP_KEEP,
        OP_ADD,
        OP_SUB
    } booth_op_e;

    function automatic booth_op_e recode(input logic q_lsb, input logic q_prev);
        booth_op_e op;
        unique case ({q_lsb, q_prev})
            2'b10:   op = OP_SUB;
            2'b01:   op = OP_ADD;
            default: op = OP_KEEP;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/booth_ctrl.sv
module booth_ctrl
    import booth_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);
    localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST_STEP = CW'(WIDTH - 1);

    booth_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          last;

    assign last = (cnt_q == LAST_STEP);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_RUN;
            ST_RUN:    if (last)  state_d = ST_FINISH;
            ST_FINISH: state_d = start ? ST_RUN : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        load = 1'b0;
        step = 1'b0;
        busy = 1'b0;
        done = 1'b0;
        unique case (state_q)
            ST_IDLE:   load = start;
            ST_RUN: begin
                step = 1'b1;
                busy = 1'b1;
            end
            ST_FINISH: begin
                done = 1'b1;
                load = start;
            end
            default: ;
        endcase
    end

    // Step counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= '0;
        else if (step) cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/booth_step.sv
module booth_step
    import booth_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH:0]   acc,
    input  logic [WIDTH:0]   mcand_ext,
    input  logic [WIDTH-1:0] mq,
    input  logic             q_prev,
    output logic [WIDTH:0]   acc_next,
    output logic [WIDTH-1:0] mq_next,
    output logic             q_prev_next
);
    booth_op_e      op;
    logic [WIDTH:0] sum;

    always_comb begin
        op = recode(mq[0], q_prev);
        unique case (op)
            OP_SUB:  sum = acc - mcand_ext;
            OP_ADD:  sum = acc + mcand_ext;
            default: sum = acc;
        endcase
        // arithmetic right shift across sum : mq : q_prev
        acc_next    = {sum[WIDTH], sum[WIDTH:1]};
        mq_next     = {sum[0], mq[WIDTH-1:1]};
        q_prev_next = mq[0];
    end

endmodule

// File: rtl/booth_datapath.sv
module booth_datapath #(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic [WIDTH-1:0]   mcand_in,
    input  logic [WIDTH-1:0]   mplier_in,
    output logic [2*WIDTH-1:0] product
);
    logic [WIDTH-1:0] m_q;
    logic [WIDTH:0]   a_q;
    logic [WIDTH-1:0] q_q;
    logic             qp_q;

    logic [WIDTH:0]   a_n;
    logic [WIDTH-1:0] q_n;
    logic             qp_n;

    booth_step #(.WIDTH(WIDTH)) step_i (
        .acc         (a_q),
        .mcand_ext   ({m_q[WIDTH-1], m_q}),
        .mq          (q_q),
        .q_prev      (qp_q),
        .acc_next    (a_n),
        .mq_next     (q_n),
        .q_prev_next (qp_n)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q  <= '0;
            a_q  <= '0;
            q_q  <= '0;
            qp_q <= 1'b0;
        end else if (load) begin
            m_q  <= mcand_in;
            a_q  <= '0;
            q_q  <= mplier_in;
            qp_q <= 1'b0;
        end else if (step) begin
            a_q  <= a_n;
            q_q  <= q_n;
            qp_q <= qp_n;
        end
    end

    assign product = {a_q[WIDTH-1:0], q_q};

endmodule

// File: rtl/booth_mult.sv
module booth_mult #(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [WIDTH-1:0]   multiplicand,
    input  logic [WIDTH-1:0]   multiplier,
    output logic               busy,
    output logic               done,
    output logic [2*WIDTH-1:0] product
);
    logic load;
    logic step;

    booth_ctrl #(.WIDTH(WIDTH)) ctrl_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .busy  (busy),
        .done  (done)
    );

    booth_datapath #(.WIDTH(WIDTH)) dp_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .mcand_in  (multiplicand),
        .mplier_in (multiplier),
        .product   (product)
    );

endmodule

// File: rtl/booth_mult_chk.sv
module booth_mult_chk #(
    parameter int WIDTH = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               busy,
    input logic               done,
    input logic [2*WIDTH-1:0] product
);
    localparam int NW = $clog2(WIDTH + 1) + 1;

    logic [NW-1:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_cnt <= '0;
        else if (busy) busy_cnt <= busy_cnt + 1'b1;
        else           busy_cnt <= '0;
    end

    a_r3_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    a_r3_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r3_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_cnt == NW'(WIDTH)) && done);

    a_r3_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    a_r2_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    a_r7_product_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(product));

endmodule

bind booth_mult booth_mult_chk #(.WIDTH(WIDTH)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .product (product)
);

// File: tb/booth_mult_tb_top.sv
module booth_mult_tb_top;

    localparam int N8 = 8;
    localparam int N4 = 4;
    localparam int NV = 16;

    // {multiplicand, multiplier, expected product}
    localparam logic [31:0] VEC [NV] = '{
        {8'd3,    8'd7,    16'h0015},
        {8'd7,    8'd3,    16'h0015},
        {8'hF9,   8'd3,    16'hFFEB},
        {8'd7,    8'hFD,   16'hFFEB},
        {8'hF9,   8'hFD,   16'h0015},
        {8'd5,    8'd30,   16'h0096},
        {8'd0,    8'hFF,   16'h0000},
        {8'hFF,   8'hFF,   16'h0001},
        {8'h7F,   8'h7F,   16'h3F01},
        {8'h80,   8'h80,   16'h4000},
        {8'h80,   8'h7F,   16'hC080},
        {8'h7F,   8'h80,   16'hC080},
        {8'h80,   8'h01,   16'hFF80},
        {8'h01,   8'h80,   16'hFF80},
        {8'hFF,   8'h7F,   16'hFF81},
        {8'd30,   8'd30,   16'h0384}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;

    logic            start8 = 1'b0;
    logic [N8-1:0]   mc8 = '0, mp8 = '0;
    logic            busy8, done8;
    logic [2*N8-1:0] prod8;

    logic            start4 = 1'b0;
    logic [N4-1:0]   mc4 = '0, mp4 = '0;
    logic            busy4, done4;
    logic [2*N4-1:0] prod4;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    booth_mult #(.WIDTH(N8)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start8),
        .multiplicand(mc8), .multiplier(mp8),
        .busy(busy8), .done(done8), .product(prod8)
    );

    booth_mult #(.WIDTH(N4)) dut4_i (
        .clk(clk), .rst_n(rst_n), .start(start4),
        .multiplicand(mc4), .multiplier(mp4),
        .busy(busy4), .done(done4), .product(prod4)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    // Start pulse at the next edge; returns at the negedge after it.
    task automatic kick8(input logic [N8-1:0] a, input logic [N8-1:0] b);
        mc8 = a; mp8 = b; start8 = 1'b1;
        @(negedge clk);
        start8 = 1'b0;
    endtask

    // Counts negedges until done; returns the count.
    task automatic wait_done8(output int n);
        n = 0;
        while (!done8 && n < 64) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic mul8(input logic [N8-1:0] a, input logic [N8-1:0] b,
                        input logic [15:0] exp, input string req);
        int n;
        kick8(a, b);
        wait_done8(n);
        chk(req, "product", 32'(prod8), 32'(exp));
        @(negedge clk);
    endtask

    task automatic mul4(input logic [N4-1:0] a, input logic [N4-1:0] b,
                        input logic [7:0] exp);
        int n;
        mc4 = a; mp4 = b; start4 = 1'b1;
        @(negedge clk);
        start4 = 1'b0;
        n = 0;
        while (!done4 && n < 32) begin
            @(negedge clk);
            n++;
        end
        chk("R4", "width4 product", 32'(prod4), 32'(exp));
        chk("R3", "width4 latency", 32'(n), 32'(N4));
        @(negedge clk);
    endtask

    initial begin
        int n;
        logic [15:0] held;

        // R1: reset state
        #5;
        chk("R1", "busy", 32'(busy8), 32'd0);
        chk("R1", "done", 32'(done8), 32'd0);
        chk("R1", "product", 32'(prod8), 32'd0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "product after release", 32'(prod8), 32'd0);

        // R4 R5: table
        for (int i = 0; i < NV; i++) begin
            mul8(VEC[i][31:24], VEC[i][23:16], VEC[i][15:0],
                 VEC[i][23] ? "R5" : "R4");
        end

        // R2 R3: timing of busy and done
        kick8(8'd9, 8'hF6);
        chk("R2", "busy after start", 32'(busy8), 32'd1);
        wait_done8(n);
        chk("R3", "cycles to done", 32'(n), 32'(N8));
        chk("R3", "busy low with done", 32'(busy8), 32'd0);
        chk("R4", "9*-10", 32'(prod8), 32'(16'hFFA6));
        @(negedge clk);
        chk("R3", "done one cycle", 32'(done8), 32'd0);

        // R6: start while busy ignored
        kick8(8'd6, 8'hFB);
        repeat (2) @(negedge clk);
        mc8 = 8'd100; mp8 = 8'd100; start8 = 1'b1;
        @(negedge clk);
        start8 = 1'b0;
        n = 3;
        while (!done8 && n < 64) begin
            @(negedge clk);
            n++;
        end
        chk("R6", "latency", 32'(n), 32'(N8));
        chk("R6", "6*-5", 32'(prod8), 32'(16'hFFE2));
        @(negedge clk);

        // R9: operand change mid-run without start
        kick8(8'hF3, 8'd11);
        mc8 = 8'h55; mp8 = 8'hAA;
        wait_done8(n);
        chk("R9", "-13*11", 32'(prod8), 32'(16'hFF71));

        // R8: back-to-back start in the done cycle
        mc8 = 8'd12; mp8 = 8'd12; start8 = 1'b1;
        @(negedge clk);
        start8 = 1'b0;
        chk("R8", "busy after start in done", 32'(busy8), 32'd1);
        wait_done8(n);
        chk("R8", "latency", 32'(n), 32'(N8));
        chk("R8", "12*12", 32'(prod8), 32'(16'h0090));

        // R7: product held while idle and operands move
        held = prod8;
        for (int k = 0; k < 6; k++) begin
            mc8 = 8'(k * 37); mp8 = 8'(k * 91);
            @(negedge clk);
        end
        chk("R7", "product held", 32'(prod8), 32'(held));
        chk("R7", "still idle", 32'(busy8), 32'd0);

        // R4 R5: strided sweep at width 8
        for (int a = -128; a < 128; a += 5) begin
            for (int b = -128; b < 128; b += 9) begin
                mul8(8'(a), 8'(b), 16'(a * b), b < 0 ? "R5" : "R4");
            end
        end

        // R4: exhaustive at width 4
        for (int a = -8; a < 8; a++) begin
            for (int b = -8; b < 8; b++) begin
                mul4(4'(a), 4'(b), 8'(a * b));
            end
        end

        finish_run();
    end

endmodule